// File: doc/BRIEF.md
# Access Wait-Cycle Calculator

This block reports how many bus cycles a single memory access will take. It works from the 28-bit target address, a two-bit access width, a hint from the processor that the access follows on from the previous one, the wait fields for four external cartridge windows and the wait setting for the on-chip work RAM. The cost appears combinationally in the same cycle as the inputs, so a bus sequencer can load its stall counter without any added latency.

Some accesses cannot use the faster sequential timing. A cartridge access is charged full first-access timing when it lands on the start of a 128 KiB page. It is also charged full timing when an idle cycle aimed at cartridge space came before it with no transfer in between. That idle condition is the only state in the block. It sits in one register that an idle strobe sets and that any read or write strobe clears. A word access to the 16-bit cartridge bus pays for two transfers.

Top module: `wait_cost_calc`

## Requirements
- R1: Address bit 27 set selects cartridge space, and bits 26:25 select window w. A non-sequential byte or half access costs the first-access time given by the window's 2-bit code in `first_code[2w+1:2w]`. Code 0 costs 5, code 1 costs 4, code 2 costs 3 and code 3 costs 9.
- R2: The sequential time of a cartridge window is 2 when `seq_code[w]` is 0. When it is 1, the time is 3 in window 0, 5 in window 1 and 9 in window 2. Window 3 always uses its first-access time as its sequential time. A sequential byte or half access costs the sequential time.
- R3: A cartridge access whose address bits 16:1 are all zero is charged as non-sequential, whatever the hint says.
- R4: Reset clears the idle flag. An idle strobe sets the flag only when address bit 27 is set. With no strobe active, the flag holds its value.
- R5: A read or write strobe clears the idle flag on the next edge. The clear wins over an idle strobe in the same cycle.
- R6: While the idle flag is set, cartridge accesses are charged as non-sequential.
- R7: A cartridge word access costs twice the sequential time when sequential. When non-sequential, it costs the first-access time plus the sequential time.
- R8: Outside cartridge space, regions 0, 1, 3, 4 and 7 (address bits 26:24) cost 1 cycle for any width.
- R9: Regions 5 and 6 cost 1 cycle, or 2 cycles for a word access.
- R10: Region 2 costs 16 minus `wram_wait`, and that cost is doubled for a word access.
- R11: Width code 0 is byte, 1 is half, 2 is word, and 3 is charged like a byte. Only code 2 applies the word rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 28 | Access address |
| acc_width | input | 2 | Access width code |
| seq_hint | input | 1 | Processor marks the access as sequential |
| first_code | input | 8 | Four 2-bit first-access wait codes, window w at bits 2w+1:2w |
| seq_code | input | 4 | Four 1-bit sequential wait codes, window w at bit w |
| wram_wait | input | 4 | Work-RAM wait setting |
| idle_stb | input | 1 | Idle cycle strobe |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| cost | output | 6 | Cycles charged for the access |
| idle_pend | output | 1 | Idle flag |

## Verification
Two events can fall in the same cycle. One is an idle strobe setting the flag, the other a read or write strobe clearing it. A related case is a charged access that reads the flag while a strobe changes it. The bench drives an idle strobe into cartridge space together with a read and expects the flag to stay clear on the next cycle. It also drives a read while the flag is set and expects that cycle to be charged non-sequential, with the flag clear one cycle later. A behavioural reference model runs alongside under directed and random stimulus, and the cost and flag are compared on every clock.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_width_e;

    typedef struct packed {
        logic pend;
    } idle_state_t;

    // first-access time for a 2-bit window code
    function automatic logic [3:0] first_cycles(input logic [1:0] code);
        case (code)
            2'd0:    first_cycles = 4'd5;
            2'd1:    first_cycles = 4'd4;
            2'd2:    first_cycles = 4'd3;
            default: first_cycles = 4'd9;
        endcase
    endfunction

    // sequential time of a window whose sequential code bit is set
    function automatic logic [3:0] seq_set_cycles(input int win);
        case (win)
            0:       seq_set_cycles = 4'd3;
            1:       seq_set_cycles = 4'd5;
            default: seq_set_cycles = 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/wcc_idle_track.sv
module wcc_idle_track
    import wcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_cart,
    input  logic idle_stb,
    input  logic xfer_stb,
    output logic pend
);
    idle_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer_stb) begin
            st_d.pend = 1'b0;
        end else if (idle_stb && in_cart) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    // R5
    xfer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |=> !pend);
    // R4
    idle_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_stb && in_cart && !xfer_stb) |=> pend);
    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_stb && !(idle_stb && in_cart)) |=> $stable(pend));

endmodule

// File: rtl/wcc_cart_cost.sv
module wcc_cart_cost
    import wcc_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int COST_W = 6,
    localparam int WIN_W = $clog2(NWIN)
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [15:0]       page_bits,
    input  logic              is_word,
    input  logic              seq_hint,
    input  logic              idle_pend,
    input  logic [2*NWIN-1:0] first_code,
    input  logic [NWIN-1:0]   seq_code,
    output logic [COST_W-1:0] cost
);
    logic [3:0] n_arr [NWIN];
    logic [3:0] s_arr [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign n_arr[w] = first_cycles(first_code[2*w +: 2]);
        if (w == NWIN - 1) begin : g_last
            assign s_arr[w] = n_arr[w];
        end else begin : g_other
            assign s_arr[w] = seq_code[w] ? seq_set_cycles(w) : 4'd2;
        end
    end

    logic [3:0] n_sel, s_sel;
    logic       seq_eff;

    always_comb begin
        n_sel   = n_arr[win];
        s_sel   = s_arr[win];
        seq_eff = seq_hint && (page_bits != 16'd0) && !idle_pend;
        if (seq_eff) begin
            cost = is_word ? COST_W'({s_sel, 1'b0}) : COST_W'(s_sel);
        end else begin
            cost = is_word ? COST_W'(n_sel) + COST_W'(s_sel) : COST_W'(n_sel);
        end
    end

endmodule

// File: rtl/wcc_local_cost.sv
module wcc_local_cost #(
    parameter int WAIT_W = 4,
    parameter int COST_W = 6
) (
    input  logic [2:0]        region,
    input  logic              is_word,
    input  logic [WAIT_W-1:0] wram_wait,
    output logic [COST_W-1:0] cost
);
    localparam int WRAM_TOP = 1 << WAIT_W;

    logic [COST_W-1:0] wram_base;

    always_comb begin
        wram_base = COST_W'(WRAM_TOP) - COST_W'(wram_wait);
        case (region)
            3'd2:      cost = is_word ? (wram_base << 1) : wram_base;
            3'd5, 3'd6: cost = is_word ? COST_W'(2) : COST_W'(1);
            default:   cost = COST_W'(1);
        endcase
    end

endmodule

// File: rtl/wait_cost_calc.sv
module wait_cost_calc
    import wcc_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int WAIT_W = 4,
    parameter int COST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [27:0]       addr,
    input  logic [1:0]        acc_width,
    input  logic              seq_hint,
    input  logic [2*NWIN-1:0] first_code,
    input  logic [NWIN-1:0]   seq_code,
    input  logic [WAIT_W-1:0] wram_wait,
    input  logic              idle_stb,
    input  logic              rd_stb,
    input  logic              wr_stb,
    output logic [COST_W-1:0] cost,
    output logic              idle_pend
);
    localparam int WIN_W = $clog2(NWIN);

    logic              in_cart, is_word;
    logic [COST_W-1:0] cart_cost, local_cost;
    logic              unused_addr;

    assign in_cart     = addr[27];
    assign is_word     = (acc_width_e'(acc_width) == ACC_WORD);
    assign unused_addr = ^{addr[23:17], addr[0]};

    wcc_idle_track i_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_cart  (in_cart),
        .idle_stb (idle_stb),
        .xfer_stb (rd_stb | wr_stb),
        .pend     (idle_pend)
    );

    wcc_cart_cost #(.NWIN(NWIN), .COST_W(COST_W)) i_cart (
        .win        (addr[25 +: WIN_W]),
        .page_bits  (addr[16:1]),
        .is_word    (is_word),
        .seq_hint   (seq_hint),
        .idle_pend  (idle_pend),
        .first_code (first_code),
        .seq_code   (seq_code),
        .cost       (cart_cost)
    );

    wcc_local_cost #(.WAIT_W(WAIT_W), .COST_W(COST_W)) i_local (
        .region    (addr[26:24]),
        .is_word   (is_word),
        .wram_wait (wram_wait),
        .cost      (local_cost)
    );

    assign cost = in_cart ? cart_cost : local_cost;

    // R8
    plain_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cart && addr[26:24] inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd7}) |-> cost == COST_W'(1));
    // R9
    video_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cart && addr[26:24] inside {3'd5, 3'd6}) |-> cost == (is_word ? COST_W'(2) : COST_W'(1)));
    // R6
    idle_forces_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cart && idle_pend && !is_word)
        |-> cost == COST_W'(first_cycles(first_code[2*addr[25 +: WIN_W] +: 2])));
    // R3
    page_forces_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cart && addr[16:1] == 16'd0 && !is_word)
        |-> cost == COST_W'(first_cycles(first_code[2*addr[25 +: WIN_W] +: 2])));

endmodule

// File: tb/test_wait_cost_calc.sv
`timescale 1ns/1ps
module test_wait_cost_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] addr = '0;
    logic [1:0]  acc_width = '0;
    logic        seq_hint = 1'b0;
    logic [7:0]  first_code = '0;
    logic [3:0]  seq_code = '0;
    logic [3:0]  wram_wait = '0;
    logic        idle_stb = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [5:0]  cost;
    logic        idle_pend;

    int compared = 0;
    int mismatched = 0;
    bit model_flag = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wait_cost_calc i_wait_cost_calc (
        .clk(clk), .rst_n(rst_n), .addr(addr), .acc_width(acc_width),
        .seq_hint(seq_hint), .first_code(first_code), .seq_code(seq_code),
        .wram_wait(wram_wait), .idle_stb(idle_stb), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .cost(cost), .idle_pend(idle_pend)
    );

    function automatic int ref_cost(logic [27:0] a, logic [1:0] w, bit sq,
                                    logic [7:0] fc, logic [3:0] sc,
                                    logic [3:0] ww, bit flag);
        int n, s, win, reg3;
        bit word;
        int ntab [4] = '{5, 4, 3, 9};
        word = (w == 2'd2);
        if (a[27]) begin
            win = a[26:25];
            n = ntab[fc[2*win +: 2]];
            case (win)
                0: s = sc[0] ? 3 : 2;
                1: s = sc[1] ? 5 : 2;
                2: s = sc[2] ? 9 : 2;
                default: s = n;
            endcase
            if (sq && a[16:1] != 0 && !flag) return word ? 2 * s : s;
            return word ? n + s : n;
        end
        reg3 = a[26:24];
        if (reg3 == 2) return (16 - ww) * (word ? 2 : 1);
        if (reg3 == 5 || reg3 == 6) return word ? 2 : 1;
        return 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic [27:0] a, logic [1:0] w, bit sq, logic [7:0] fc,
                        logic [3:0] sc, logic [3:0] ww, bit istb, bit rd,
                        bit wr, string tag);
        @(negedge clk);
        addr = a; acc_width = w; seq_hint = sq; first_code = fc;
        seq_code = sc; wram_wait = ww; idle_stb = istb; rd_stb = rd; wr_stb = wr;
        #1;
        check(tag, int'(cost), ref_cost(a, w, sq, fc, sc, ww, model_flag));
        check({tag, " flag"}, int'(idle_pend), int'(model_flag));
        @(posedge clk);
        if (rd || wr) model_flag = 1'b0;
        else if (istb && a[27]) model_flag = 1'b1;
    endtask

    function automatic logic [27:0] cart(int win, logic [15:0] page);
        return {1'b1, 2'(win), 8'h00, page, 1'b0};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset", int'(idle_pend), 0);
        rst_n = 1'b1;

        // R1: first-access table per window, byte and half
        for (int win = 0; win < 4; win++)
            for (int c = 0; c < 4; c++)
                step(cart(win, 16'h0040), 2'(c % 2), 1'b0, 8'(c << (2 * win)),
                     4'h0, 4'h0, 0, 0, 0, "R1");
        // R2: sequential per window, code clear and set
        for (int win = 0; win < 4; win++) begin
            step(cart(win, 16'h0123), 2'd1, 1'b1, 8'h1B, 4'h0, 4'h0, 0, 0, 0, "R2");
            step(cart(win, 16'h0123), 2'd0, 1'b1, 8'hE4, 4'hF, 4'h0, 0, 0, 0, "R2");
        end
        // R3: page start forces first access
        step(cart(1, 16'h0000), 2'd0, 1'b1, 8'h00, 4'hF, 4'h0, 0, 0, 0, "R3");
        step(cart(2, 16'h0000), 2'd2, 1'b1, 8'h30, 4'hF, 4'h0, 0, 0, 0, "R3");
        // R4: idle outside cart space has no effect; inside it sets
        step(28'h200_0010, 2'd0, 1'b0, 8'h00, 4'h0, 4'h0, 1, 0, 0, "R4");
        step(cart(0, 16'h0010), 2'd0, 1'b1, 8'h00, 4'h1, 4'h0, 0, 0, 0, "R4");
        step(cart(0, 16'h0010), 2'd0, 1'b0, 8'h00, 4'h1, 4'h0, 1, 0, 0, "R4");
        // R6: flag forces first access, held across quiet cycles
        step(cart(2, 16'h0010), 2'd1, 1'b1, 8'h20, 4'h4, 4'h0, 0, 0, 0, "R6");
        step(cart(2, 16'h0010), 2'd2, 1'b1, 8'h20, 4'h4, 4'h0, 0, 0, 0, "R6 R7");
        // R5: read charged with flag, then clears it
        step(cart(0, 16'h0010), 2'd0, 1'b1, 8'h03, 4'h1, 4'h0, 0, 1, 0, "R5");
        step(cart(0, 16'h0010), 2'd0, 1'b1, 8'h03, 4'h1, 4'h0, 0, 0, 0, "R5");
        // R5: idle and write together, clear wins
        step(cart(3, 16'h0010), 2'd0, 1'b1, 8'h40, 4'h0, 4'h0, 1, 0, 1, "R5");
        step(cart(3, 16'h0010), 2'd0, 1'b1, 8'h40, 4'h0, 4'h0, 0, 0, 0, "R5");
        // R7: word, sequential and not
        step(cart(1, 16'h0200), 2'd2, 1'b1, 8'h0C, 4'h2, 4'h0, 0, 0, 0, "R7");
        step(cart(1, 16'h0200), 2'd2, 1'b0, 8'h0C, 4'h2, 4'h0, 0, 0, 0, "R7");
        step(cart(3, 16'h0200), 2'd2, 1'b1, 8'hC0, 4'h0, 4'h0, 0, 0, 0, "R7");
        // R8, R9, R10, R11: internal regions
        for (int r = 0; r < 8; r++)
            for (int w = 0; w < 4; w++)
                step({1'b0, 3'(r), 24'h00_1234}, 2'(w), 1'b1, 8'h00, 4'h0, 4'(r * 3 + w),
                     0, 0, 0, (r == 2) ? "R10 R11" : (r == 5 || r == 6) ? "R9 R11" : "R8");
        step(28'h200_0000, 2'd2, 1'b0, 8'h00, 4'h0, 4'h0, 0, 0, 0, "R10");
        step(28'h200_0000, 2'd2, 1'b0, 8'h00, 4'h0, 4'hF, 0, 0, 0, "R10");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [27:0] a;
            logic [1:0] w;
            int k;
            string tag;
            a = 28'($urandom);
            k = $urandom % 8;
            if (k == 0) a[16:1] = '0;
            w = 2'($urandom);
            if (a[27]) tag = (w == 2) ? "R7" : model_flag ? "R6" : (a[16:1] == 0) ? "R3" : "R2";
            else tag = (a[26:24] == 2) ? "R10" : (a[26:24] inside {5, 6}) ? "R9" : "R8";
            step(a, w, 1'($urandom), 8'($urandom), 4'($urandom), 4'($urandom),
                 ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, tag);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule